// File: doc/BRIEF.md
# DMA Channel Register Port

This block is the processor-facing register file of a four-channel DMA engine. Software reaches it through an 8-bit data path and a 4-bit register offset. Each channel has a 16-bit starting address and a 16-bit starting count. Software writes these as two bytes through the same offset. A reading of the same offset returns the live address or count that the transfer engine reports back. The block also holds the channel masks, the per-channel transfer mode, a command byte, the software request bits and the terminal-count flags, and it decodes the one-shot software commands.

A single byte-order pointer, shared by all channels, chooses whether an access to a 16-bit register touches its low byte or its high byte. The pointer is a two-state machine:
- `PTR_LO`: the next 16-bit access hits bits 7:0.
- `PTR_HI`: the next 16-bit access hits bits 15:8.

It has three transitions:
- *step*: any read or write at offsets 0x0–0x7 moves `PTR_LO` to `PTR_HI`, or `PTR_HI` to `PTR_LO`.
- *clear*: a pointer-reset write or a master clear forces `PTR_LO`. Clear has priority over step.
- *hold*: with no access, the state stays where it is.

The transfer engine takes the starting values, the mode fields, the masks and a combined per-channel request from this block. It returns the current address and count and a one-cycle terminal-count pulse per channel.

Top module: `dma_host_regs`

## Requirements
- R1: Channel n's address register sits at offset 2n and its count register at offset 2n+1. A write stores the data byte into the starting value (`base_addr_o` or `base_cnt_o`, slice n). In `PTR_LO` the byte goes to bits 7:0, and in `PTR_HI` it goes to bits 15:8.
- R2: A read at offset 2n returns a byte of `cur_addr_i` slice n, and a read at offset 2n+1 returns a byte of `cur_cnt_i` slice n. The pointer state picks the byte. `rdata` is combinational while `rd_en` is high.
- R3: Every access at offsets 0x0–0x7 toggles the shared pointer. A write at offset 0xC returns it to `PTR_LO`.
- R4: A write at offset 0x8 loads `cmd_o`. A read at offset 0x8 returns the status byte: terminal-count flags in bits 3:0, and pending requests (`drq_i | swreq_o`) in bits 7:4.
- R5: A `tc_i[n]` pulse sets terminal-count flag n. A status read clears all the flags at the clock edge that ends the read. A pulse that arrives in the same cycle as the read still leaves its flag set.
- R6: A write at offset 0x9 sets software request `swreq_o[wdata[1:0]]` to the value of `wdata[2]`. `tc_i[n]` clears `swreq_o[n]`.
- R7: A write at offset 0xA sets `mask_o[wdata[1:0]]` to the value of `wdata[2]`.
- R8: A write at offset 0xB programs channel `wdata[1:0]`. It sets the direction to `wdata[3:2]` (`dir_o`), auto-reload to `wdata[4]` (`autoinit_o`), and the mode to `wdata[7:6]` (`xmode_o`). The mode codes are 00 demand, 01 single, 10 block and 11 cascade.
- R9: A write at offset 0xD (master clear) has these effects:
  - it sets all masks;
  - it forces `PTR_LO`;
  - it clears the terminal-count flags, the software requests and `cmd_o`.
  The starting values and the mode fields are kept.
- R10: A write at offset 0xE clears all masks. A write at offset 0xF loads all masks from `wdata[3:0]`.
- R11: `req_o[n]` is `(drq_i[n] & ~mask_o[n]) | swreq_o[n]`, so a masked channel ignores its hardware request.
- R12: After reset, these values hold:
  - all masks are set and the pointer is `PTR_LO`;
  - the command, modes, starting values, flags and software requests are zero;
  - `rdata` is zero when no read is active and for read offsets 0x9–0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register port select |
| wr_en | input | 1 | Write strobe (one cycle per access) |
| rd_en | input | 1 | Read strobe (one cycle per access) |
| offset | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| drq_i | input | 4 | Hardware request per channel |
| tc_i | input | 4 | Terminal-count pulse per channel from the transfer engine |
| cur_addr_i | input | 64 | Current address per channel, 16 bits each |
| cur_cnt_i | input | 64 | Current count per channel, 16 bits each |
| base_addr_o | output | 64 | Starting address per channel |
| base_cnt_o | output | 64 | Starting count per channel |
| mask_o | output | 4 | Channel mask bits |
| cmd_o | output | 8 | Command byte |
| dir_o | output | 8 | Direction field per channel, 2 bits each |
| autoinit_o | output | 4 | Auto-reload enable per channel |
| xmode_o | output | 8 | Transfer mode per channel, 2 bits each |
| swreq_o | output | 4 | Software request bits |
| req_o | output | 4 | Armed request per channel |

## Verification
The bench builds the block with its default 8-bit data path and four channels. At that size every offset decodes to a real register, and every channel index in the mask, request and mode writes is reachable. Both pointer states are driven through reads and through writes. The pointer is left in `PTR_HI` before it is cleared by offset 0xC and by master clear, so the clear transition is seen acting on a non-reset state. The status path is exercised at the cycle where a terminal-count pulse coincides with a clearing read.

// File: rtl/dma_host_pkg.sv
package dma_host_pkg;
    localparam int NCH  = 4;
    localparam int CH_W = $clog2(NCH);
    localparam int OFS_W = 4;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } byte_ptr_e;

    typedef enum logic [1:0] {
        XM_DEMAND  = 2'b00,
        XM_SINGLE  = 2'b01,
        XM_BLOCK   = 2'b10,
        XM_CASCADE = 2'b11
    } xfer_mode_e;

    localparam logic [OFS_W-1:0] OFS_CMD_STAT = 4'h8;
    localparam logic [OFS_W-1:0] OFS_REQ      = 4'h9;
    localparam logic [OFS_W-1:0] OFS_MASK1    = 4'hA;
    localparam logic [OFS_W-1:0] OFS_MODE     = 4'hB;
    localparam logic [OFS_W-1:0] OFS_PTR_CLR  = 4'hC;
    localparam logic [OFS_W-1:0] OFS_MCLR     = 4'hD;
    localparam logic [OFS_W-1:0] OFS_MASK_CLR = 4'hE;
    localparam logic [OFS_W-1:0] OFS_MASK_ALL = 4'hF;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr
    import dma_host_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    output logic ptr_hi
);
    byte_ptr_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_LO: if (clear) state_d = PTR_LO;
                    else if (step) state_d = PTR_HI;
            PTR_HI: if (clear || step) state_d = PTR_LO;
            default: state_d = PTR_LO;
        endcase
    end

    always_comb begin
        ptr_hi = (state_q == PTR_HI);
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_addr,
    input  logic            wr_cnt,
    input  logic            hi,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] base_addr,
    output logic [2*DW-1:0] base_cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
        end else begin
            if (wr_addr) begin
                if (hi) base_addr[2*DW-1:DW] <= wdata;
                else    base_addr[DW-1:0]    <= wdata;
            end
            if (wr_cnt) begin
                if (hi) base_cnt[2*DW-1:DW] <= wdata;
                else    base_cnt[DW-1:0]    <= wdata;
            end
        end
    end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_host_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [OFS_W-1:0] offset,
    input  logic [DW-1:0]    wdata,
    input  logic             stat_rd,
    input  logic [NCH-1:0]   tc_i,
    output logic [NCH-1:0]   mask,
    output logic [DW-1:0]    cmd,
    output logic [NCH-1:0]   swreq,
    output logic [NCH-1:0]   tc_flags,
    output logic [2*NCH-1:0] dir,
    output logic [NCH-1:0]   autoinit,
    output logic [2*NCH-1:0] xmode
);
    logic [CH_W-1:0]           sel;
    logic                      mclr;
    logic [NCH-1:0]            swreq_d;
    logic [NCH-1:0]            tc_d;
    logic [NCH-1:0][1:0]       dir_q;
    logic [NCH-1:0][1:0]       xm_q;
    logic                      unused_mode_bit;

    assign sel             = wdata[CH_W-1:0];
    assign mclr            = wr && (offset == OFS_MCLR);
    assign unused_mode_bit = wdata[5];

    always_comb begin
        swreq_d = swreq;
        if (wr && offset == OFS_REQ) swreq_d[sel] = wdata[2];
        swreq_d = swreq_d & ~tc_i;
        tc_d    = (tc_flags & ~{NCH{stat_rd}}) | tc_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask     <= '1;
            cmd      <= '0;
            swreq    <= '0;
            tc_flags <= '0;
            dir_q    <= '0;
            xm_q     <= '0;
            autoinit <= '0;
        end else if (mclr) begin
            mask     <= '1;
            cmd      <= '0;
            swreq    <= '0;
            tc_flags <= '0;
        end else begin
            swreq    <= swreq_d;
            tc_flags <= tc_d;
            if (wr) begin
                case (offset)
                    OFS_CMD_STAT: cmd <= wdata;
                    OFS_MASK1:    mask[sel] <= wdata[2];
                    OFS_MODE: begin
                        dir_q[sel]    <= wdata[3:2];
                        autoinit[sel] <= wdata[4];
                        xm_q[sel]     <= wdata[7:6];
                    end
                    OFS_MASK_CLR: mask <= '0;
                    OFS_MASK_ALL: mask <= wdata[NCH-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign dir   = dir_q;
    assign xmode = xm_q;
endmodule

// File: rtl/dma_host_regs.sv
module dma_host_regs
    import dma_host_pkg::*;
#(
    parameter int DW = 8,
    localparam int REG_W = 2 * DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [OFS_W-1:0]   offset,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    input  logic [NCH-1:0]     drq_i,
    input  logic [NCH-1:0]     tc_i,
    input  logic [NCH*REG_W-1:0] cur_addr_i,
    input  logic [NCH*REG_W-1:0] cur_cnt_i,
    output logic [NCH*REG_W-1:0] base_addr_o,
    output logic [NCH*REG_W-1:0] base_cnt_o,
    output logic [NCH-1:0]     mask_o,
    output logic [DW-1:0]      cmd_o,
    output logic [2*NCH-1:0]   dir_o,
    output logic [NCH-1:0]     autoinit_o,
    output logic [2*NCH-1:0]   xmode_o,
    output logic [NCH-1:0]     swreq_o,
    output logic [NCH-1:0]     req_o
);
    logic wr, rd, data_acc, ptr_clr, stat_rd, ptr_hi;
    logic [NCH-1:0] tc_flags;
    logic [CH_W-1:0] rd_ch;
    logic [REG_W-1:0] rd_word;

    assign wr       = cs && wr_en;
    assign rd       = cs && rd_en && !wr_en;
    assign data_acc = (wr || rd) && !offset[OFS_W-1];
    assign ptr_clr  = wr && (offset == OFS_PTR_CLR || offset == OFS_MCLR);
    assign stat_rd  = rd && (offset == OFS_CMD_STAT);

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (data_acc),
        .clear  (ptr_clr),
        .ptr_hi (ptr_hi)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        logic hit;
        assign hit = wr && !offset[OFS_W-1] && (offset[OFS_W-2:1] == n[CH_W-1:0]);
        dma_chan_regs #(.DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_addr   (hit && !offset[0]),
            .wr_cnt    (hit && offset[0]),
            .hi        (ptr_hi),
            .wdata     (wdata),
            .base_addr (base_addr_o[n*REG_W +: REG_W]),
            .base_cnt  (base_cnt_o[n*REG_W +: REG_W])
        );
    end

    dma_ctrl_regs #(.DW(DW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr),
        .offset   (offset),
        .wdata    (wdata),
        .stat_rd  (stat_rd),
        .tc_i     (tc_i),
        .mask     (mask_o),
        .cmd      (cmd_o),
        .swreq    (swreq_o),
        .tc_flags (tc_flags),
        .dir      (dir_o),
        .autoinit (autoinit_o),
        .xmode    (xmode_o)
    );

    assign req_o = (drq_i & ~mask_o) | swreq_o;

    assign rd_ch = offset[OFS_W-2:1];

    always_comb begin
        rd_word = offset[0] ? cur_cnt_i[rd_ch*REG_W +: REG_W]
                            : cur_addr_i[rd_ch*REG_W +: REG_W];
        rdata = '0;
        if (rd && !offset[OFS_W-1]) begin
            rdata = ptr_hi ? rd_word[REG_W-1:DW] : rd_word[DW-1:0];
        end else if (stat_rd) begin
            rdata = DW'({drq_i | swreq_o, tc_flags});
        end
    end
endmodule

// File: rtl/dma_host_regs_chk.sv
module dma_host_regs_chk
    import dma_host_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cs,
    input logic             wr_en,
    input logic             rd_en,
    input logic [OFS_W-1:0] offset,
    input logic [NCH-1:0]   drq_i,
    input logic [NCH-1:0]   tc_i,
    input logic [NCH-1:0]   mask_o,
    input logic [7:0]       cmd_o,
    input logic [NCH-1:0]   swreq_o,
    input logic [NCH-1:0]   req_o,
    input logic [NCH-1:0]   tc_flags,
    input logic             ptr_hi
);
    logic acc16, wr_c, wr_d, wr_e, st_rd;
    assign acc16 = cs && (wr_en || rd_en) && !offset[3];
    assign wr_c  = cs && wr_en && offset == 4'hC;
    assign wr_d  = cs && wr_en && offset == 4'hD;
    assign wr_e  = cs && wr_en && offset == 4'hE;
    assign st_rd = cs && rd_en && !wr_en && offset == 4'h8;

    assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc16 |=> (ptr_hi != $past(ptr_hi)));

    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c |=> !ptr_hi);

    assert_master_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_d |=> (mask_o == '1 && cmd_o == '0 && tc_flags == '0 && swreq_o == '0 && !ptr_hi));

    assert_mask_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_e |=> (mask_o == '0));

    assert_masked_drq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((drq_i & mask_o & ~swreq_o & req_o) == '0));

    assert_tc_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc_i && !wr_d) |=> ((tc_flags & $past(tc_i)) == $past(tc_i)));

    assert_tc_rdclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd && tc_i == '0) |=> (tc_flags == '0));

    assert_tc_drops_swreq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        |tc_i |=> ((swreq_o & $past(tc_i)) == '0));
endmodule

bind dma_host_regs dma_host_regs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .offset   (offset),
    .drq_i    (drq_i),
    .tc_i     (tc_i),
    .mask_o   (mask_o),
    .cmd_o    (cmd_o),
    .swreq_o  (swreq_o),
    .req_o    (req_o),
    .tc_flags (tc_flags),
    .ptr_hi   (ptr_hi)
);

// File: tb/tb_dma_host_regs.sv
`timescale 1ns/1ps
module tb_dma_host_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  offset = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [3:0]  drq_i = '0, tc_i = '0;
    logic [63:0] cur_addr_i = '0, cur_cnt_i = '0;
    logic [63:0] base_addr_o, base_cnt_o;
    logic [3:0]  mask_o, autoinit_o, swreq_o, req_o;
    logic [7:0]  cmd_o, dir_o, xmode_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dma_host_regs dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
        .offset(offset), .wdata(wdata), .rdata(rdata), .drq_i(drq_i), .tc_i(tc_i),
        .cur_addr_i(cur_addr_i), .cur_cnt_i(cur_cnt_i),
        .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o), .mask_o(mask_o),
        .cmd_o(cmd_o), .dir_o(dir_o), .autoinit_o(autoinit_o), .xmode_o(xmode_o),
        .swreq_o(swreq_o), .req_o(req_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] o, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr_en = 1'b1; offset = o; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] o, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd_en = 1'b1; offset = o;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd_en = 1'b0;
    endtask

    task automatic pulse_tc(input logic [3:0] v);
        @(negedge clk);
        tc_i = v;
        @(negedge clk);
        tc_i = '0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R12 mask", mask_o, 4'hF);
        chk("R12 cmd", cmd_o, 8'h00);
        chk("R12 base", base_addr_o, 64'h0);
        chk("R12 idle rdata", rdata, 8'h00);
        rd(4'h8, d); chk("R12 status", d, 8'h00);
        rd(4'hB, d); chk("R12 unused read", d, 8'h00);
    endtask

    task automatic t_base_write;
        wr(4'hC, 8'h00);
        wr(4'h2, 8'h34); wr(4'h2, 8'h12);
        chk("R1 ch1 addr", base_addr_o[31:16], 16'h1234);
        wr(4'h7, 8'hCD); wr(4'h7, 8'hAB);
        chk("R1 ch3 count", base_cnt_o[63:48], 16'hABCD);
        chk("R1 ch0 untouched", base_addr_o[15:0], 16'h0000);
    endtask

    task automatic t_cur_read;
        logic [7:0] d;
        cur_addr_i[47:32] = 16'hBEEF;
        cur_cnt_i[47:32]  = 16'h5A6B;
        wr(4'hC, 8'h00);
        rd(4'h4, d); chk("R2 addr low", d, 8'hEF);
        rd(4'h4, d); chk("R2 addr high", d, 8'hBE);
        wr(4'h0, 8'h11);
        rd(4'h5, d); chk("R3 pointer shared write then read", d, 8'h5A);
    endtask

    task automatic t_ptr_clear;
        wr(4'h0, 8'h77);
        wr(4'hC, 8'h00);
        wr(4'h0, 8'h22); wr(4'h0, 8'h33);
        chk("R3 clear returns to low", base_addr_o[15:0], 16'h3322);
    endtask

    task automatic t_mode;
        wr(4'hB, 8'hD6);
        chk("R8 dir ch2", dir_o[5:4], 2'b01);
        chk("R8 autoinit ch2", autoinit_o, 4'b0100);
        chk("R8 mode ch2 cascade", xmode_o[5:4], 2'b11);
        chk("R8 ch0 untouched", {xmode_o[1:0], dir_o[1:0]}, 4'h0);
    endtask

    task automatic t_mask;
        drq_i = 4'b0101;
        #1 chk("R11 masked ignores drq", req_o, 4'b0000);
        wr(4'hA, 8'h00);
        chk("R7 single clear", mask_o, 4'b1110);
        chk("R11 armed ch0", req_o, 4'b0001);
        wr(4'hE, 8'h00);
        chk("R10 clear all", mask_o, 4'b0000);
        chk("R11 all armed", req_o, 4'b0101);
        wr(4'hF, 8'h0A);
        chk("R10 load all", mask_o, 4'b1010);
        wr(4'hA, 8'h04);
        chk("R7 single set", mask_o, 4'b1011);
        chk("R11 ch0 masked again", req_o, 4'b0100);
    endtask

    task automatic t_cmd_status;
        logic [7:0] d;
        wr(4'h8, 8'hA5);
        chk("R4 command", cmd_o, 8'hA5);
        drq_i = 4'b0001;
        wr(4'h9, 8'h06);
        chk("R6 sw request set", swreq_o, 4'b0100);
        chk("R11 sw request bypasses mask", req_o, 4'b0100);
        rd(4'h8, d); chk("R4 status pending", d, 8'h50);
        pulse_tc(4'b0100);
        chk("R6 tc drops sw request", swreq_o, 4'b0000);
        rd(4'h8, d); chk("R5 tc flag", d, 8'h14);
        rd(4'h8, d); chk("R5 cleared by read", d, 8'h10);
        @(negedge clk);
        cs = 1'b1; rd_en = 1'b1; offset = 4'h8; tc_i = 4'b0010;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd_en = 1'b0; tc_i = '0;
        chk("R5 read during pulse", d, 8'h10);
        rd(4'h8, d); chk("R5 set wins over read", d, 8'h12);
        rd(4'h8, d); chk("R5 cleared after", d, 8'h10);
    endtask

    task automatic t_master;
        logic [7:0] d;
        pulse_tc(4'b0001);
        wr(4'h9, 8'h05);
        wr(4'h0, 8'h99);
        drq_i = 4'b0000;
        wr(4'hD, 8'h00);
        chk("R9 masks set", mask_o, 4'hF);
        chk("R9 command cleared", cmd_o, 8'h00);
        chk("R9 sw request cleared", swreq_o, 4'h0);
        rd(4'h8, d); chk("R9 status cleared", d, 8'h00);
        wr(4'h0, 8'h44); wr(4'h0, 8'h55);
        chk("R9 pointer low", base_addr_o[15:0], 16'h5544);
        chk("R9 mode kept", {xmode_o[5:4], dir_o[5:4]}, 4'b1101);
        chk("R9 base kept", base_cnt_o[63:48], 16'hABCD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_base_write;
        t_cur_read;
        t_ptr_clear;
        t_mode;
        t_mask;
        t_cmd_status;
        t_master;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule